// File: doc/BRIEF.md
# Clock correction sequence matcher

The block watches the 10-bit symbol stream that enters a receive elastic buffer and compares it with one or two programmed correction sequences. Each sequence has up to four 10-bit subsequences. A 4-bit enable mask can turn any subsequence into a wildcard. A length selector sets how many subsequences take part in the match. Symbols can be compared in one of two forms: the decoder's output (8 data bits plus the K-character flag and the running disparity), or the raw 10-bit parallel word.

When a sequence completes, the block raises a match pulse. If the buffer occupancy is outside the programmed latency band at that moment, the block also asks the buffer controller for a correction. An occupancy below the lower limit gives an insert request, so the sequence is written once more. An occupancy above the upper limit gives a delete request, so the matched sequence is dropped. A hold-off keeps the block from correcting the same sequence twice. The match mode is meant to be changed only while the stream is idle, because the symbol history is stored already converted to the selected form.

Top module: `cc_seq_match`

## Requirements
- R1: While rst_ni is low, and after it rises until the first valid symbol has been processed, match_o, ins_o and del_o are 0.
- R2: With L = len_sel_i + 1, a sequence matches when the last L valid symbols equal subsequences 1..L. Subsequence 1 is the oldest of these symbols, and subsequence k sits in bits [10k-1:10k-10] of the sequence port. match_o is 1 in the cycle after the valid cycle that carried the last symbol.
- R3: When bit k-1 of a sequence's enable mask is 0, subsequence k of that sequence matches any symbol.
- R4: The second sequence can cause a match only while use2_i is 1. Sequence 1 can always cause a match.
- R5: With dec_mode_i = 1, each symbol compares as {disp_i, k_i, sym_i[7:0]}. With dec_mode_i = 0, it compares as sym_i[9:0].
- R6: A match that is not held off, with occ_i < min_lat_i, gives ins_o = 1 in the same cycle as match_o.
- R7: A match that is not held off, with occ_i > max_lat_i and occ_i >= min_lat_i, gives del_o = 1 in the same cycle as match_o. ins_o and del_o are never 1 together.
- R8: A match with min_lat_i <= occ_i <= max_lat_i gives neither ins_o nor del_o.
- R9: After an insert or delete request, the next L-1 valid symbols cause no further request, even if they complete a match.
- R10: Cycles with valid_i = 0 do not shift the symbol history. The cycle after such a cycle has match_o, ins_o and del_o at 0.
- R11: No match is reported until at least L valid symbols have arrived since reset, even when every subsequence is a wildcard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | A symbol is present in this cycle |
| sym_i | input | 10 | Symbol: raw word, or data in bits [7:0] |
| k_i | input | 1 | K-character flag from the decoder |
| disp_i | input | 1 | Running disparity from the decoder |
| dec_mode_i | input | 1 | 1 = compare decoded form, 0 = compare raw form |
| len_sel_i | input | 2 | Detection length minus one |
| seq1_i | input | 40 | Subsequences of sequence 1 |
| en1_i | input | 4 | Wildcard mask of sequence 1 (0 = wildcard) |
| seq2_i | input | 40 | Subsequences of sequence 2 |
| en2_i | input | 4 | Wildcard mask of sequence 2 |
| use2_i | input | 1 | Lets sequence 2 trigger a match |
| occ_i | input | 6 | Current buffer occupancy |
| min_lat_i | input | 6 | Lower latency limit |
| max_lat_i | input | 6 | Upper latency limit |
| match_o | output | 1 | A sequence has completed |
| ins_o | output | 1 | Request to insert a copy of the sequence |
| del_o | output | 1 | Request to drop the sequence |

## Verification
Assertions check several properties on every cycle. Insert and delete requests are never raised together, and each one comes with a match. Each request agrees with the occupancy in the previous cycle: an insert only when it was below the lower limit, a delete only when it was above the upper limit. An idle cycle leaves the next cycle quiet, and an active hold-off blocks requests. Whether a given symbol history actually matches depends on the order of symbols, the wildcard masks, the length, the second-sequence gate and the compare form. Only the bench's scenarios can show this, because its reference model compares the design against that history on every clock.

// File: rtl/cc_pkg.sv
package cc_pkg;
  localparam int SYM_W = 10;
  localparam int NSUB  = 4;
  localparam int OCC_W = 6;

  // decoded form keeps data byte plus K flag and disparity
  function automatic logic [SYM_W-1:0] sym_key(input logic dec, input logic [SYM_W-1:0] sym,
                                               input logic k, input logic disp);
    return dec ? {disp, k, sym[SYM_W-3:0]} : sym;
  endfunction
endpackage

// File: rtl/cc_sym_window.sv
module cc_sym_window #(
  parameter int SYM_W  = 10,
  parameter int DEPTH  = 3,
  parameter int FILL_W = $clog2(DEPTH + 1)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         valid_i,
  input  logic [SYM_W-1:0]             key_i,
  output logic [DEPTH-1:0][SYM_W-1:0]  hist_o,
  output logic [FILL_W-1:0]            fill_o
);
  logic [DEPTH-1:0][SYM_W-1:0] hist_q;
  logic [FILL_W-1:0]           fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (valid_i) begin
      hist_q[0] <= key_i;
      for (int i = 1; i < DEPTH; i++) hist_q[i] <= hist_q[i-1];
      if (int'(fill_q) < DEPTH) fill_q <= fill_q + 1'b1;
    end
  end

  assign hist_o = hist_q;
  assign fill_o = fill_q;
endmodule

// File: rtl/cc_seq_cmp.sv
module cc_seq_cmp #(
  parameter int SYM_W  = 10,
  parameter int NSUB   = 4,
  parameter int LEN_W  = $clog2(NSUB),
  parameter int FILL_W = $clog2(NSUB)
) (
  input  logic                          valid_i,
  input  logic [SYM_W-1:0]              cur_i,
  input  logic [NSUB-2:0][SYM_W-1:0]    hist_i,
  input  logic [FILL_W-1:0]             fill_i,
  input  logic [LEN_W-1:0]              len_i,
  input  logic [NSUB-1:0][SYM_W-1:0]    pat_i,
  input  logic [NSUB-1:0]               en_i,
  output logic                          hit_o
);
  logic             all_ok;
  logic [SYM_W-1:0] sel;
  int               len, age;

  always_comb begin
    all_ok = 1'b1;
    len    = int'(len_i) + 1;
    sel    = '0;
    age    = 0;
    for (int j = 0; j < NSUB; j++) begin
      if (j < len && en_i[j]) begin
        age = len - 1 - j;  // subsequence 1 is oldest
        sel = (age == 0) ? cur_i : hist_i[age-1];
        if (sel != pat_i[j]) all_ok = 1'b0;
      end
    end
    hit_o = valid_i && (int'(fill_i) >= len - 1) && all_ok;
  end
endmodule

// File: rtl/cc_corr_ctrl.sv
module cc_corr_ctrl #(
  parameter int OCC_W = 6,
  parameter int LEN_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic             hit_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [OCC_W-1:0] occ_i,
  input  logic [OCC_W-1:0] min_lat_i,
  input  logic [OCC_W-1:0] max_lat_i,
  output logic             match_o,
  output logic             ins_o,
  output logic             del_o
);
  logic             low, high, fire;
  logic             match_q, ins_q, del_q;
  logic [LEN_W-1:0] hold_q;

  assign low  = occ_i < min_lat_i;
  assign high = !low && (occ_i > max_lat_i);
  assign fire = valid_i && hit_i && (hold_q == '0) && (low || high);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      match_q <= 1'b0;
      ins_q   <= 1'b0;
      del_q   <= 1'b0;
      hold_q  <= '0;
    end else begin
      match_q <= valid_i && hit_i;
      ins_q   <= fire && low;
      del_q   <= fire && high;
      if (fire)                          hold_q <= len_i;  // L-1 symbols
      else if (valid_i && hold_q != '0)  hold_q <= hold_q - 1'b1;
    end
  end

  assign match_o = match_q;
  assign ins_o   = ins_q;
  assign del_o   = del_q;

  p_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni) !(ins_o && del_o));
  p_ins_low_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_o |-> $past(occ_i < min_lat_i));
  p_del_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    del_o |-> $past(occ_i > max_lat_i));
  p_corr_match_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_o || del_o) |-> match_o);
  p_band_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (occ_i >= min_lat_i && occ_i <= max_lat_i) |=> !(ins_o || del_o));
  p_gap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !(match_o || ins_o || del_o));
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && hold_q != '0) |=> !(ins_o || del_o));
endmodule

// File: rtl/cc_seq_match.sv
module cc_seq_match
  import cc_pkg::*;
#(
  parameter int SW = SYM_W,
  parameter int NS = NSUB,
  parameter int OW = OCC_W,
  parameter int LW = $clog2(NSUB)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [SW-1:0]    sym_i,
  input  logic             k_i,
  input  logic             disp_i,
  input  logic             dec_mode_i,
  input  logic [LW-1:0]    len_sel_i,
  input  logic [NS*SW-1:0] seq1_i,
  input  logic [NS-1:0]    en1_i,
  input  logic [NS*SW-1:0] seq2_i,
  input  logic [NS-1:0]    en2_i,
  input  logic             use2_i,
  input  logic [OW-1:0]    occ_i,
  input  logic [OW-1:0]    min_lat_i,
  input  logic [OW-1:0]    max_lat_i,
  output logic             match_o,
  output logic             ins_o,
  output logic             del_o
);
  localparam int HIST   = NS - 1;
  localparam int FILL_W = $clog2(HIST + 1);

  logic [SW-1:0]                key;
  logic [HIST-1:0][SW-1:0]      hist;
  logic [FILL_W-1:0]            fill;
  logic [1:0][NS-1:0][SW-1:0]   pats;
  logic [1:0][NS-1:0]           ens;
  logic [1:0]                   hits;
  logic                         hit;

  assign key     = sym_key(dec_mode_i, sym_i, k_i, disp_i);
  assign pats[0] = seq1_i;
  assign pats[1] = seq2_i;
  assign ens[0]  = en1_i;
  assign ens[1]  = en2_i;

  cc_sym_window #(.SYM_W(SW), .DEPTH(HIST), .FILL_W(FILL_W)) i_window (
    .clk_i, .rst_ni, .valid_i, .key_i(key), .hist_o(hist), .fill_o(fill)
  );

  for (genvar s = 0; s < 2; s++) begin : g_seq
    cc_seq_cmp #(.SYM_W(SW), .NSUB(NS), .LEN_W(LW), .FILL_W(FILL_W)) i_cmp (
      .valid_i, .cur_i(key), .hist_i(hist), .fill_i(fill), .len_i(len_sel_i),
      .pat_i(pats[s]), .en_i(ens[s]), .hit_o(hits[s])
    );
  end

  assign hit = hits[0] || (use2_i && hits[1]);

  cc_corr_ctrl #(.OCC_W(OW), .LEN_W(LW)) i_ctrl (
    .clk_i, .rst_ni, .valid_i, .hit_i(hit), .len_i(len_sel_i), .occ_i,
    .min_lat_i, .max_lat_i, .match_o, .ins_o, .del_o
  );

  p_seq2_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !use2_i && !hits[0]) |=> !match_o);
endmodule

// File: tb/test_cc_seq_match.sv
`timescale 1ns/1ps
module test_cc_seq_match;
  localparam logic [9:0] A = 10'h283, B = 10'h17C, C = 10'h2AA, D = 10'h155;
  localparam logic [9:0] X = 10'h0F0, Z = 10'h333, E = 10'h0C3, F = 10'h30F;
  localparam logic [9:0] G = 10'h1E1, H = 10'h21E;

  logic clk = 0, rst_ni = 0;
  logic valid = 0, k = 0, disp = 0, dec = 0, use2 = 0;
  logic [9:0] sym = '0;
  logic [1:0] len_sel = 2'd3;
  logic [39:0] seq1 = '0, seq2 = '0;
  logic [3:0] en1 = '0, en2 = '0;
  logic [5:0] occ = 6'd8, min_lat = 6'd4, max_lat = 6'd12;
  logic match_o, ins_o, del_o;

  int tests = 0, fails = 0, hold = 0;
  string req = "R1";
  logic [9:0] hq[$];
  logic e_match = 0, e_ins = 0, e_del = 0;

  always #2 clk = ~clk;

  cc_seq_match i_cc_seq_match (
    .clk_i(clk), .rst_ni, .valid_i(valid), .sym_i(sym), .k_i(k), .disp_i(disp),
    .dec_mode_i(dec), .len_sel_i(len_sel), .seq1_i(seq1), .en1_i(en1), .seq2_i(seq2),
    .en2_i(en2), .use2_i(use2), .occ_i(occ), .min_lat_i(min_lat), .max_lat_i(max_lat),
    .match_o, .ins_o, .del_o
  );

  function automatic logic [9:0] mkey(logic d, logic [9:0] s, logic kk, logic dp);
    if (d) return {dp, kk, s[7:0]};
    return s;
  endfunction

  function automatic bit seq_hit(logic [39:0] sq, logic [3:0] en, logic [9:0] cur);
    int L = int'(len_sel) + 1;
    if (hq.size() < L - 1) return 0;
    for (int j = 0; j < L; j++) begin
      logic [9:0] s;
      int age = L - 1 - j;
      s = (age == 0) ? cur : hq[age-1];
      if (en[j] && s != sq[j*10 +: 10]) return 0;
    end
    return 1;
  endfunction

  task automatic chk(string nm, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %b expected %b at %0t", req, nm, act, exp, $time);
    end
  endtask

  // drive at negedge, model, compare just after posedge
  task automatic step(logic v, logic [9:0] s, logic kk = 0, logic dp = 0);
    logic [9:0] cur;
    bit h, lo, hi, fire;
    valid = v; sym = s; k = kk; disp = dp;
    cur  = mkey(dec, s, kk, dp);
    h    = v && (seq_hit(seq1, en1, cur) || (use2 && seq_hit(seq2, en2, cur)));
    lo   = occ < min_lat;
    hi   = !lo && occ > max_lat;
    fire = h && hold == 0 && (lo || hi);
    e_match = h; e_ins = fire && lo; e_del = fire && hi;
    if (fire) hold = int'(len_sel);
    else if (v && hold > 0) hold--;
    if (v) begin
      hq.push_front(cur);
      if (hq.size() > 3) void'(hq.pop_back());
    end
    @(posedge clk); #1;
    chk("match_o", match_o, e_match);
    chk("ins_o", ins_o, e_ins);
    chk("del_o", del_o, e_del);
    @(negedge clk);
  endtask

  task automatic flush(int n);
    occ = 6'd8;
    for (int i = 0; i < n; i++) step(1, X);
  endtask

  task automatic do_reset();
    rst_ni = 0; valid = 0; hq.delete(); hold = 0;
    @(negedge clk); #1;
    req = "R1";
    chk("match_o", match_o, 0); chk("ins_o", ins_o, 0); chk("del_o", del_o, 0);
    @(negedge clk); rst_ni = 1;
  endtask

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    seq1 = {D, C, B, A}; en1 = 4'hF; seq2 = {H, G, F, E}; en2 = 4'hF;
    do_reset();
    req = "R1"; step(1, A);
    // R2 / R8: full-length match inside band
    req = "R8"; step(1, X); step(1, A); step(1, B); step(1, C); step(1, D);
    // R6 insert below band
    req = "R6"; occ = 6'd2; step(1, A); step(1, B); step(1, C); step(1, D); flush(3);
    // R7 delete above band
    req = "R7"; occ = 6'd20; step(1, A); step(1, B); step(1, C); step(1, D); flush(3);
    // R3 wildcard on subsequence 2
    req = "R3"; en1 = 4'b1101; occ = 6'd2; step(1, A); step(1, Z); step(1, C); step(1, D);
    flush(3); en1 = 4'hF;
    // R4 second sequence gate
    req = "R4"; step(1, E); step(1, F); step(1, G); step(1, H);
    use2 = 1; step(1, E); step(1, F); step(1, G); step(1, H); use2 = 0; flush(3);
    // R5 decoded vs raw
    req = "R5"; dec = 1; len_sel = 2'd0; seq1 = {30'd0, 1'b0, 1'b1, 8'hBC}; en1 = 4'b0001;
    step(1, 10'h0BC, 1, 0); step(1, 10'h0BC, 0, 0); step(1, 10'h0BC, 1, 1); step(1, 10'h3BC, 1, 0);
    dec = 0; step(1, 10'h0BC, 1, 0); step(1, 10'h1BC, 1, 0);
    // R9 hold-off with overlapping matches
    req = "R9"; len_sel = 2'd1; seq1 = {20'd0, A, A}; en1 = 4'b0011; flush(3); occ = 6'd2;
    step(1, A); step(1, A); step(1, A); step(1, A); step(1, A); flush(2);
    // R10 idle cycles between symbols
    req = "R10"; len_sel = 2'd3; seq1 = {D, C, B, A}; en1 = 4'hF; occ = 6'd20;
    step(1, A); step(0, X); step(1, B); step(0, D); step(1, C); step(0, C); step(1, D); step(0, D);
    flush(3);
    // R11 history fill after reset, all wildcards
    do_reset();
    req = "R11"; en1 = 4'h0; occ = 6'd8; step(1, X); step(1, X); step(1, X); step(1, X); step(1, X);
    en1 = 4'hF;
    // mixed traffic
    req = "R2";
    for (int i = 0; i < 600; i++) begin
      logic [9:0] pick[5] = '{A, B, C, D, X};
      if (i % 50 == 0) len_sel = 2'($urandom_range(0, 3));
      use2 = 1'($urandom_range(0, 1));
      seq2 = {B, A, D, C};
      occ  = 6'($urandom_range(0, 20));
      step($urandom_range(0, 9) < 8, pick[$urandom_range(0, 4)]);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule